// File: doc/BRIEF.md
# Per-Processor Counter/Timer Bank with User Mode

This block holds one counter/timer for each processor of a small multiprocessor and a shared mode register that decides, processor by processor, how each timer behaves. In counter mode a timer always runs, counts up to a programmable limit, wraps to zero, latches a reached flag and raises that processor's interrupt. In user mode the same timer becomes a 54-period (63-bit value) free-running counter. Software starts and stops it, loads it as a high and a low word, and it never interrupts.

Every timer advances in steps of 0x200 (the low nine bits of the count value are always zero), one step per tick. A tick is produced every `TICK_CYCLES` clocks. All registers are reached over one simple bus. `bus_tgt` value 0 selects the system target, which holds the mode register. `bus_tgt` value i+1 selects the timer of processor i. Word offsets are given on `bus_addr`. Reads return data combinationally in the same cycle as `bus_en`, and any side effect of an access takes place on that clock edge.

Top module: `ptimer_bank`

## Requirements
- R1: After a synchronous active-low reset, the mode register reads 0, every timer is in counter mode with running bit 1 and limit 0 (free-run), and every `cpu_irq` bit is low.
- R2: A running timer advances its count value by 0x200 on every tick, one tick per `TICK_CYCLES` clocks, in both modes. A stopped user-mode timer holds its value.
- R3: In counter mode, a write to offset 0 sets the limit to bits 30:9 of the data, clears the count and lowers the interrupt. When the count reaches the limit, it wraps to 0, the reached flag is set and the interrupt goes high. A limit of 0 means free-running up to 0x7FFFFE00. A read of offset 1 returns {reached, count bits 30:9, nine zeros}.
- R4: In counter mode, a read of offset 0 returns the limit and clears both the reached flag and the interrupt. A write to offset 2 changes the limit without clearing the count.
- R5: The mode register is offset 4 of the system target, and bit i selects user mode for processor i. Bits at N_CPU and above are ignored and read as 0. A write to offset 4 of a processor target has no effect.
- R6: Switching a timer to user mode lowers its interrupt, clears its running bit and clears its count.
- R7: Switching a timer back to counter mode sets its running bit, clears its count and resets its limit to free-run. No tick is counted in the cycle of the switch.
- R8: In user mode, a write to offset 0 loads the high word (bits 30:0), and a write to offset 1 loads the low word (bits 31:9, with 8:0 kept zero). Either write clears the reached flag. A read of offset 0 returns {reached, high word}, and a read of offset 1 returns the low word.
- R9: In user mode, bit 0 written to offset 3 starts (1) or stops (0) the timer. A read of offset 3 on a processor target returns the running bit. In counter mode a write to offset 3 is ignored. The system target reads offset 3 as 0.
- R10: A user-mode timer stepping from 0x7FFFFFFF_FFFFFC00 wraps to 0 and sets its reached flag, and its interrupt stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_tgt | input | TGT_W | 0 = system target, i+1 = processor i timer |
| bus_addr | input | 3 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| cpu_irq | output | N_CPU | Per-processor interrupt, level |

## Verification
The bench builds the bank with N_CPU = 3, which gives a 2-bit target field and leaves mode-register bits 3 and above unimplemented, so the ignored upper bits can be exercised. TICK_CYCLES = 4 makes limit reach, wrap and start/stop windows of a few ticks take only tens of cycles. Loading the user counter one step below its maximum brings the 63-bit wrap within reach.

// File: rtl/ptimer_pkg.sv
// Package: shared widths and register offsets of the processor timer bank.
// Assumes a 32-bit register bus with word offsets on a 3-bit address.
package ptimer_pkg;
    localparam int DATA_W    = 32;
    localparam int PAD_BITS  = 9;   // count value bits below one tick step
    localparam int CTR_PER_W = 22;  // counter-mode tick field (value bits 30:9)
    localparam int USR_PER_W = 54;  // user-mode tick field (value bits 62:9)
    localparam int LO_PER_W  = 23;  // tick bits carried by the low word
    localparam int HI_W      = USR_PER_W - LO_PER_W;

    typedef enum logic [2:0] {
        REG_LIMIT_HI   = 3'd0,
        REG_COUNT_LO   = 3'd1,
        REG_LIMIT_KEEP = 3'd2,
        REG_RUN        = 3'd3,
        REG_MODE       = 3'd4
    } reg_off_e;
endpackage

// File: rtl/ptimer_tick_gen.sv
// Tick generator: one-cycle pulse every TICK_CYCLES clocks.
// Assumes TICK_CYCLES >= 1; the phase restarts at reset.
module ptimer_tick_gen #(
    parameter int TICK_CYCLES = 100
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int DIV_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [DIV_W-1:0] DIV_TOP = DIV_W'(TICK_CYCLES - 1);

    logic [DIV_W-1:0] div_q;

    // Purpose: free-running divider, wraps at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n)              div_q <= '0;
        else if (div_q == DIV_TOP) div_q <= '0;
        else                     div_q <= div_q + 1'b1;
    end

    assign tick = rst_n && (div_q == DIV_TOP);
endmodule

// File: rtl/ptimer_mode_reg.sv
// Mode register: bit i puts processor timer i in user mode.
// Emits one-cycle switch pulses on the write edge for bits that change.
module ptimer_mode_reg #(
    parameter int N_CPU = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [N_CPU-1:0] wdata,
    output logic [N_CPU-1:0] mode_q,
    output logic [N_CPU-1:0] to_user,
    output logic [N_CPU-1:0] to_ctr
);
    // Purpose: hold the per-processor mode bits.
    always_ff @(posedge clk) begin
        if (!rst_n)     mode_q <= '0;
        else if (wr_en) mode_q <= wdata;
    end

    // Purpose: decode which timers change mode on this write.
    always_comb begin
        to_user = wr_en ? (wdata & ~mode_q) : '0;
        to_ctr  = wr_en ? (~wdata & mode_q) : '0;
    end
endmodule

// File: rtl/ptimer_cpu_slice.sv
// One processor timer. Counter mode: limit counter with interrupt.
// User mode: start/stop 63-bit counter without interrupt.
// Assumes at most one bus access per cycle and that mode pulses come
// from the shared mode register in the same cycle as its write.
module ptimer_cpu_slice
    import ptimer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              user_mode,
    input  logic              to_user,
    input  logic              to_ctr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [2:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    logic [USR_PER_W-1:0] cnt_q, cnt_d, cnt_inc, top;
    logic [CTR_PER_W-1:0] lim_q, lim_d, top_ctr;
    logic                 reached_q, reached_d;
    logic                 irq_q, irq_d;
    logic                 run_q, run_d;
    logic                 advance;

    // Purpose: pick the wrap point for the current mode.
    always_comb begin
        top_ctr = (lim_q == '0) ? {CTR_PER_W{1'b1}} : lim_q;
        top     = user_mode ? {USR_PER_W{1'b1}}
                            : {{(USR_PER_W-CTR_PER_W){1'b0}}, top_ctr};
        cnt_inc = cnt_q + 1'b1;
        advance = tick && (user_mode ? run_q : 1'b1);
    end

    // Purpose: next state; mode switch beats writes, writes beat ticks.
    always_comb begin
        cnt_d     = cnt_q;
        lim_d     = lim_q;
        reached_d = reached_q;
        irq_d     = irq_q;
        run_d     = run_q;
        if (rd_en && addr == REG_LIMIT_HI && !user_mode) begin
            reached_d = 1'b0;
            irq_d     = 1'b0;
        end
        if (advance) begin
            if (cnt_inc == top) begin
                cnt_d     = '0;
                reached_d = 1'b1;
                if (!user_mode) irq_d = 1'b1;
            end else begin
                cnt_d = cnt_inc;
            end
        end
        if (wr_en) begin
            unique case (addr)
                REG_LIMIT_HI: begin
                    cnt_d     = cnt_q;
                    reached_d = reached_q;
                    irq_d     = irq_q;
                    if (user_mode) begin
                        cnt_d     = {wdata[HI_W-1:0], cnt_q[LO_PER_W-1:0]};
                        reached_d = 1'b0;
                    end else begin
                        lim_d = wdata[DATA_W-2:PAD_BITS];
                        cnt_d = '0;
                        irq_d = 1'b0;
                    end
                end
                REG_COUNT_LO: begin
                    if (user_mode) begin
                        cnt_d     = {cnt_q[USR_PER_W-1:LO_PER_W], wdata[DATA_W-1:PAD_BITS]};
                        reached_d = 1'b0;
                        irq_d     = irq_q;
                    end
                end
                REG_LIMIT_KEEP: begin
                    if (!user_mode) lim_d = wdata[DATA_W-2:PAD_BITS];
                end
                REG_RUN: begin
                    if (user_mode) run_d = wdata[0];
                end
                default: ;
            endcase
        end
        if (to_user) begin
            cnt_d = '0;
            irq_d = 1'b0;
            run_d = 1'b0;
        end else if (to_ctr) begin
            cnt_d = '0;
            lim_d = '0;
            run_d = 1'b1;
        end
    end

    // Purpose: timer state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            lim_q     <= '0;
            reached_q <= 1'b0;
            irq_q     <= 1'b0;
            run_q     <= 1'b1;
        end else begin
            cnt_q     <= cnt_d;
            lim_q     <= lim_d;
            reached_q <= reached_d;
            irq_q     <= irq_d;
            run_q     <= run_d;
        end
    end

    // Purpose: read data for this timer's offsets.
    always_comb begin
        rdata = '0;
        unique case (addr)
            REG_LIMIT_HI:
                rdata = user_mode ? {reached_q, cnt_q[USR_PER_W-1:LO_PER_W]}
                                  : {1'b0, lim_q, {PAD_BITS{1'b0}}};
            REG_COUNT_LO:
                rdata = user_mode ? {cnt_q[LO_PER_W-1:0], {PAD_BITS{1'b0}}}
                                  : {reached_q, cnt_q[CTR_PER_W-1:0], {PAD_BITS{1'b0}}};
            REG_RUN: rdata = {{(DATA_W-1){1'b0}}, run_q};
            default: rdata = '0;
        endcase
    end

    assign irq = irq_q;
endmodule

// File: rtl/ptimer_bank.sv
// Top: tick generator, mode register and N_CPU timer slices on one bus.
// Target 0 is the system target (mode register only); target i+1 is
// processor i. Assumes N_CPU between 1 and 16.
module ptimer_bank
    import ptimer_pkg::*;
#(
    parameter int N_CPU       = 4,
    parameter int TICK_CYCLES = 100,
    parameter int TGT_W       = $clog2(N_CPU + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic [TGT_W-1:0]  bus_tgt,
    input  logic [2:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [N_CPU-1:0]  cpu_irq
);
    logic                         tick;
    logic                         sys_sel, mode_wr;
    logic [N_CPU-1:0]             mode_q, to_user, to_ctr, cpu_sel;
    logic [N_CPU-1:0][DATA_W-1:0] slice_rd;

    ptimer_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    assign sys_sel = bus_en && (bus_tgt == '0);
    assign mode_wr = sys_sel && bus_wr && (bus_addr == REG_MODE);

    ptimer_mode_reg #(.N_CPU(N_CPU)) u_mode (
        .clk(clk), .rst_n(rst_n), .wr_en(mode_wr),
        .wdata(bus_wdata[N_CPU-1:0]), .mode_q(mode_q),
        .to_user(to_user), .to_ctr(to_ctr)
    );

    for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
        assign cpu_sel[i] = bus_en && (bus_tgt == TGT_W'(i + 1));
        ptimer_cpu_slice u_slice (
            .clk(clk), .rst_n(rst_n), .tick(tick),
            .user_mode(mode_q[i]), .to_user(to_user[i]), .to_ctr(to_ctr[i]),
            .wr_en(cpu_sel[i] && bus_wr), .rd_en(cpu_sel[i] && !bus_wr),
            .addr(bus_addr), .wdata(bus_wdata),
            .rdata(slice_rd[i]), .irq(cpu_irq[i])
        );
    end

    // Purpose: return the addressed target's read data.
    always_comb begin
        bus_rdata = '0;
        if (sys_sel && bus_addr == REG_MODE)
            bus_rdata = {{(DATA_W-N_CPU){1'b0}}, mode_q};
        for (int i = 0; i < N_CPU; i++)
            if (cpu_sel[i]) bus_rdata = slice_rd[i];
    end
endmodule

// File: rtl/ptimer_bank_chk.sv
// Checker for ptimer_bank: interrupt and mode-register properties.
// Bound to every instance of the top module.
module ptimer_bank_chk #(
    parameter int N_CPU = 4,
    parameter int TGT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_en,
    input logic             bus_wr,
    input logic [TGT_W-1:0] bus_tgt,
    input logic [2:0]       bus_addr,
    input logic [31:0]      bus_wdata,
    input logic [N_CPU-1:0] mode_q,
    input logic             tick,
    input logic [N_CPU-1:0] cpu_irq
);
    AST_USER_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_irq & mode_q) == '0); // R10

    AST_MODE_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_wr && bus_tgt == '0 && bus_addr == 3'd4)
        |=> (mode_q == $past(bus_wdata[N_CPU-1:0]))); // R5

    for (genvar i = 0; i < N_CPU; i++) begin : g_p
        AST_LIMIT_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_en && !bus_wr && bus_tgt == TGT_W'(i + 1) && bus_addr == 3'd0
             && !mode_q[i] && !tick) |=> !cpu_irq[i]); // R4

        AST_IRQ_RISES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(cpu_irq[i]) |-> $past(tick)); // R3
    end
endmodule

bind ptimer_bank ptimer_bank_chk #(.N_CPU(N_CPU), .TGT_W(TGT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_tgt(bus_tgt), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .mode_q(mode_q), .tick(tick), .cpu_irq(cpu_irq)
);

// File: tb/ptimer_bank_test.sv
`timescale 1ns/1ps
module ptimer_bank_test;
    localparam int N  = 3;
    localparam int T  = 4;
    localparam int TW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_en = 1'b0, bus_wr = 1'b0;
    logic [TW-1:0] bus_tgt = '0;
    logic [2:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  cpu_irq;
    int total = 0, bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ptimer_bank #(.N_CPU(N), .TICK_CYCLES(T), .TGT_W(TW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_tgt(bus_tgt), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cpu_irq(cpu_irq)
    );

    function automatic logic [31:0] f_hi(input logic r, input logic [31:0] v);
        return {r, v[30:0]};
    endfunction
    function automatic logic [31:0] f_lo(input logic [31:0] v);
        return {v[31:9], 9'b0};
    endfunction
    function automatic logic [31:0] f_mode(input logic [31:0] v);
        return v & ((32'd1 << N) - 1);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask
    task automatic chk_rng(input string req, input logic [31:0] act,
                           input logic [31:0] lo, input logic [31:0] hi);
        total++;
        if (act < lo || act > hi) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h..%h", req, act, lo, hi);
        end
    endtask

    // Called at a falling edge; the access takes effect on the next rising edge.
    task automatic wr(input int t, input int a, input logic [31:0] d);
        bus_en = 1; bus_wr = 1; bus_tgt = TW'(t); bus_addr = 3'(a); bus_wdata = d;
        @(negedge clk);
        bus_en = 0; bus_wr = 0;
    endtask
    task automatic rd(input int t, input int a, output logic [31:0] d);
        bus_en = 1; bus_wr = 0; bus_tgt = TW'(t); bus_addr = 3'(a);
        #1 d = bus_rdata;
        @(negedge clk);
        bus_en = 0;
    endtask
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, c1, c2, hi, lo, m;
        void'($urandom(32'd4711));
        idle(5);
        rst_n = 1;
        // R1: reset state
        rd(0, 4, v); chk("R1 mode", v, 0);
        rd(1, 3, v); chk("R1 running", v, 1);
        rd(2, 0, v); chk("R1 limit", v, 0);
        chk("R1 irq", {29'b0, cpu_irq}, 0);
        idle(3 * T);
        rd(1, 1, v); chk_rng("R2 free-run advances", v, 32'h200, 32'h800);

        // R3: limit counting on processor 0
        wr(1, 0, 32'h0000_0800);
        idle(2 * T);
        chk("R3 irq before limit", {31'b0, cpu_irq[0]}, 0);
        idle(3 * T);
        chk("R3 irq at limit", {31'b0, cpu_irq[0]}, 1);
        rd(1, 1, c1); chk("R3 reached bit", {31'b0, c1[31]}, 1);
        // R4: offset 2 keeps the count
        wr(1, 2, 32'h7FFF_FE00);
        rd(1, 1, c2);
        chk_rng("R4 count kept", c2 & 32'h7FFF_FFFF, c1 & 32'h7FFF_FFFF, (c1 & 32'h7FFF_FFFF) + 32'h400);
        rd(1, 0, v); chk("R4 limit read", v, 32'h7FFF_FE00);
        chk("R4 irq cleared", {31'b0, cpu_irq[0]}, 0);
        rd(1, 1, v); chk("R4 reached cleared", {31'b0, v[31]}, 0);
        // R9: run write ignored in counter mode, system offset 3 reads 0
        wr(1, 3, 32'h0);
        rd(1, 3, v); chk("R9 counter run ignored", v, 1);
        rd(0, 3, v); chk("R9 system run zero", v, 0);

        // R6: switch processor 0 with a pending interrupt
        wr(1, 0, 32'h0000_0400);
        idle(3 * T);
        chk("R6 irq pending", {31'b0, cpu_irq[0]}, 1);
        wr(0, 4, 32'h1);
        chk("R6 irq dropped", {31'b0, cpu_irq[0]}, 0);
        rd(1, 3, v); chk("R6 running cleared", v, 0);
        rd(1, 1, v); chk("R6 count cleared", v, 0);

        // R2: user start/stop on processor 0
        wr(1, 3, 32'h1);
        idle(8 * T);
        wr(1, 3, 32'h0);
        rd(1, 1, c1); chk_rng("R2 user ticks", c1, 32'h200 * 7, 32'h200 * 9);
        rd(1, 3, v); chk("R9 stopped", v, 0);
        idle(3 * T);
        rd(1, 1, v); chk("R2 stopped holds", v, c1);

        // R10: wrap at the 63-bit maximum
        wr(1, 0, 32'h7FFF_FFFF);
        wr(1, 1, 32'hFFFF_FC00);
        rd(1, 0, v); chk("R8 high load", v, 32'h7FFF_FFFF);
        rd(1, 1, v); chk("R8 low load", v, 32'hFFFF_FC00);
        wr(1, 3, 32'h1);
        idle(2 * T);
        wr(1, 3, 32'h0);
        chk("R10 no irq", {31'b0, cpu_irq[0]}, 0);
        rd(1, 0, v); chk("R10 reached", v, 32'h8000_0000);
        rd(1, 1, v); chk_rng("R10 wrapped", v, 32'h200, 32'h400);
        wr(1, 1, 32'h1234_57FF);
        rd(1, 0, v); chk("R8 write clears reached", v, 0);
        rd(1, 1, v); chk("R8 low pad zero", v, 32'h1234_5600);

        // R7: back to counter mode
        wr(0, 4, 32'h0);
        rd(1, 1, v); chk("R7 count cleared", v, 0);
        rd(1, 3, v); chk("R7 running", v, 1);
        rd(1, 0, v); chk("R7 free-run limit", v, 0);
        idle(3 * T);
        rd(1, 1, v); chk_rng("R7 counts again", v, 32'h200, 32'h800);

        // R5: processor offset 4 ignored
        wr(1, 4, 32'h7);
        rd(0, 4, v); chk("R5 processor mode write ignored", v, 0);

        // R8: random word loads on processor 2 in user mode
        wr(0, 4, 32'h4);
        for (int k = 0; k < 24; k++) begin
            hi = $urandom; lo = $urandom;
            wr(3, 0, hi); wr(3, 1, lo);
            rd(3, 0, v); chk("R8 random high", v, f_hi(1'b0, hi));
            rd(3, 1, v); chk("R8 random low", v, f_lo(lo));
        end
        // R5: random mode values, upper bits ignored
        for (int k = 0; k < 12; k++) begin
            m = $urandom;
            wr(0, 4, m);
            rd(0, 4, v); chk("R5 random mode", v, f_mode(m));
            chk("R10 user irq low", {29'b0, cpu_irq & v[N-1:0]}, 0);
        end
        wr(0, 4, 32'hFFFF_FFF8);
        rd(0, 4, v); chk("R5 upper bits zero", v, 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule